// File: doc/BRIEF.md
# RapidIO Request Legality Checker

This block screens incoming RapidIO I/O logical-layer requests before they reach the local memory master. Header fields are sampled when a packet starts. When the packet ends, the block takes the payload byte count and the CRC result and issues one registered verdict: accept, illegal, or pass-through. The checks cover priority, payload presence, the size/doubleword-pointer code, the match against programmable address windows, full-width read sizes, payload length and header length.

Illegal requests of a type that expects a reply also raise a one-cycle ERROR-response request. A separate input path raises the same request when a local read finishes with an error. Good-CRC packets whose transaction type is not handled here go to the pass-through verdict for user logic. Bad-CRC packets get no verdict.

Top module: `rio_req_check`

## Requirements
- R1: The verdict is registered. One clock after `pkt_end`, exactly one of `o_accept`, `o_illegal`, `o_pass` is high for one cycle when `i_crc_ok` is high. None of them is high when `i_crc_ok` is low. All outputs are low in reset.
- R2: A handled request (see R10) with priority field `i_prio` = 3 is illegal.
- R3: An NWRITE or NWRITE_R with a payload count of 0 is illegal. An NREAD with a nonzero payload count is illegal.
- R4: NREAD, NWRITE, NWRITE_R and SWRITE must hit an address window. Window i hits when `win_en[i]` is set and `(addr & mask_i) == (base_i & mask_i)`. Window i occupies bits [i*ADDR_W +: ADDR_W] of `win_base` and `win_mask`. A disabled window never hits.
- R5: Writes (NWRITE, NWRITE_R, ATOMIC) with size code 4'b1101 and pointer 0, or with size codes 4'b1110 or 4'b1111, use reserved encodings and are illegal.
- R6: An NREAD is illegal unless its size/pointer code gives a byte count that is a multiple of BUS_BYTES (8). Only size codes 4'b1011 and above qualify.
- R7: For NWRITE, NWRITE_R and ATOMIC, a payload count that differs from the count implied by the size/pointer code is illegal. An SWRITE payload must be a nonzero multiple of 8 no greater than 256. Any handled request with `i_hdr_bytes` below HDR_MIN (12) is illegal.
- R8: An illegal NREAD, NWRITE_R or ATOMIC raises `o_err_rsp` in the same cycle as `o_illegal`. An illegal NWRITE or SWRITE does not.
- R9: `rd_last` and `rd_err` high together raise `o_err_rsp` one clock later.
- R10: Handled types are NREAD (ftype 2, ttype 4), NWRITE (ftype 5, ttype 4), NWRITE_R (ftype 5, ttype 5), ATOMIC (ftype 5, ttypes 12 to 14) and SWRITE (ftype 6). Any other good-CRC packet gets `o_pass`, regardless of its other fields.
- R11: Header fields are captured on `pkt_start`. A later `pkt_end` is judged on the captured fields, even if the header inputs have changed since.
- R12: Size/pointer byte counts follow this map (size code: bytes for pointer 0 / pointer 1):
  - 0 to 3: 1/1
  - 4: 2/2
  - 5: 3/3
  - 6: 2/2
  - 7: 5/5
  - 8: 4/4
  - 9: 6/6
  - 10: 7/7
  - 11: 8/16
  - 12: 32/64
  - 13: 96/128
  - 14: 160/192 (reads only)
  - 15: 224/256 (reads only)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Header fields valid; capture them |
| i_ftype | input | 4 | Format type |
| i_ttype | input | 4 | Transaction field |
| i_prio | input | 2 | Priority |
| i_size | input | 4 | Read/write size code |
| i_wdptr | input | 1 | Doubleword pointer |
| i_addr | input | ADDR_W | Request address |
| i_hdr_bytes | input | 8 | Bytes of header received |
| pkt_end | input | 1 | Packet complete; judge it |
| i_pay_bytes | input | PAY_W | Payload byte count |
| i_crc_ok | input | 1 | CRC valid |
| rd_last | input | 1 | Final beat of a local read |
| rd_err | input | 1 | Local read error |
| win_en | input | NWIN | Window enables |
| win_base | input | NWIN*ADDR_W | Window bases |
| win_mask | input | NWIN*ADDR_W | Window masks |
| o_accept | output | 1 | Legal request verdict |
| o_illegal | output | 1 | Illegal request verdict |
| o_pass | output | 1 | Pass-through verdict |
| o_err_rsp | output | 1 | ERROR response request |

## Verification
The block holds state in two places: the captured header and the verdict register. A wrong captured header shows up on a split start/end packet as the wrong verdict, one clock after `pkt_end`. A stuck verdict register shows up as a second pulse on the following cycle, or as two verdict outputs high together. Both are visible within two cycles of the packet end. Decode faults in size, window or type classification surface as a wrong verdict or a wrong `o_err_rsp` on the same cycle as the verdict. They are compared against an independent bench model over random and directed packets.

// File: rtl/rio_chk_pkg.sv
package rio_chk_pkg;
   typedef enum logic [2:0] {
      K_NREAD, K_NWRITE, K_NWRITE_R, K_SWRITE, K_ATOMIC, K_OTHER
   } req_kind_t;

   typedef struct packed {
      logic [3:0] ftype;
      logic [3:0] ttype;
      logic [1:0] prio;
      logic [3:0] size;
      logic       wdptr;
      logic [7:0] hdr_bytes;
   } hdr_t;
endpackage

// File: rtl/rio_type_classify.sv
module rio_type_classify
   import rio_chk_pkg::*;
(
   input  logic [3:0] ftype,
   input  logic [3:0] ttype,
   output req_kind_t  kind,
   output logic       wants_rsp,
   output logic       is_read
);
   always_comb begin
      kind = K_OTHER;
      unique case (ftype)
         4'd2: if (ttype == 4'd4) kind = K_NREAD;
         4'd5: begin
            if (ttype == 4'd4)      kind = K_NWRITE;
            else if (ttype == 4'd5) kind = K_NWRITE_R;
            else if (ttype >= 4'd12 && ttype <= 4'd14) kind = K_ATOMIC;
         end
         4'd6: kind = K_SWRITE;
         default: kind = K_OTHER;
      endcase
   end

   assign wants_rsp = (kind == K_NREAD) || (kind == K_NWRITE_R) || (kind == K_ATOMIC);
   assign is_read   = (kind == K_NREAD);
endmodule

// File: rtl/rio_size_decode.sv
module rio_size_decode #(
   parameter int CNT_W = 9
) (
   input  logic [3:0]       size,
   input  logic             wdptr,
   input  logic             is_read,
   output logic             ok,
   output logic [CNT_W-1:0] bytes
);
   if (CNT_W < 9) begin : g_bad_cnt
      $error("rio_size_decode: CNT_W must hold 256");
   end

   logic [8:0] b;
   always_comb begin
      ok = 1'b1;
      b  = 9'd1;
      case (size)
         4'd4, 4'd6: b = 9'd2;
         4'd5:  b = 9'd3;
         4'd7:  b = 9'd5;
         4'd8:  b = 9'd4;
         4'd9:  b = 9'd6;
         4'd10: b = 9'd7;
         4'd11: b = wdptr ? 9'd16 : 9'd8;
         4'd12: b = wdptr ? 9'd64 : 9'd32;
         4'd13: begin
            b  = wdptr ? 9'd128 : 9'd96;
            ok = wdptr | is_read;
         end
         4'd14: begin
            b  = wdptr ? 9'd192 : 9'd160;
            ok = is_read;
         end
         4'd15: begin
            b  = wdptr ? 9'd256 : 9'd224;
            ok = is_read;
         end
         default: b = 9'd1;
      endcase
      bytes = CNT_W'(b);
   end
endmodule

// File: rtl/rio_addr_windows.sv
module rio_addr_windows #(
   parameter int ADDR_W = 32,
   parameter int NWIN   = 4
) (
   input  logic [ADDR_W-1:0]      addr,
   input  logic [NWIN-1:0]        win_en,
   input  logic [NWIN*ADDR_W-1:0] win_base,
   input  logic [NWIN*ADDR_W-1:0] win_mask,
   output logic                   hit
);
   if (NWIN < 1) begin : g_bad_nwin
      $error("rio_addr_windows: NWIN must be at least 1");
   end

   logic [NWIN-1:0] per_win;
   for (genvar i = 0; i < NWIN; i++) begin : g_win
      logic [ADDR_W-1:0] m;
      assign m = win_mask[i*ADDR_W +: ADDR_W];
      assign per_win[i] = win_en[i] &&
                          ((addr & m) == (win_base[i*ADDR_W +: ADDR_W] & m));
   end
   assign hit = |per_win;

   always_comb begin
      if (win_en == '0) assert_no_hit_when_all_off_R4: assert (!hit);
   end
endmodule

// File: rtl/rio_req_check.sv
module rio_req_check
   import rio_chk_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int NWIN      = 4,
   parameter int PAY_W     = 9,
   parameter int BUS_BYTES = 8,
   parameter int HDR_MIN   = 12,
   parameter int SW_MAX    = 256
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pkt_start,
   input  logic [3:0]             i_ftype,
   input  logic [3:0]             i_ttype,
   input  logic [1:0]             i_prio,
   input  logic [3:0]             i_size,
   input  logic                   i_wdptr,
   input  logic [ADDR_W-1:0]      i_addr,
   input  logic [7:0]             i_hdr_bytes,
   input  logic                   pkt_end,
   input  logic [PAY_W-1:0]       i_pay_bytes,
   input  logic                   i_crc_ok,
   input  logic                   rd_last,
   input  logic                   rd_err,
   input  logic [NWIN-1:0]        win_en,
   input  logic [NWIN*ADDR_W-1:0] win_base,
   input  logic [NWIN*ADDR_W-1:0] win_mask,
   output logic                   o_accept,
   output logic                   o_illegal,
   output logic                   o_pass,
   output logic                   o_err_rsp
);
   localparam int LANE_LG = $clog2(BUS_BYTES);

   if (BUS_BYTES < 2 || (1 << LANE_LG) != BUS_BYTES) begin : g_bad_bus
      $error("rio_req_check: BUS_BYTES must be a power of two");
   end
   if (PAY_W < 9) begin : g_bad_pay
      $error("rio_req_check: PAY_W must hold 256");
   end

   hdr_t              hdr_q, hdr_live, hdr_use;
   logic [ADDR_W-1:0] addr_q, addr_use;

   assign hdr_live = '{ftype: i_ftype, ttype: i_ttype, prio: i_prio,
                       size: i_size, wdptr: i_wdptr, hdr_bytes: i_hdr_bytes};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hdr_q  <= '0;
         addr_q <= '0;
      end else if (pkt_start) begin
         hdr_q  <= hdr_live;
         addr_q <= i_addr;
      end
   end

   assign hdr_use  = pkt_start ? hdr_live : hdr_q;
   assign addr_use = pkt_start ? i_addr   : addr_q;

   req_kind_t        kind;
   logic             wants_rsp, is_read;
   logic             sz_ok, win_hit;
   logic [PAY_W-1:0] sz_bytes;

   rio_type_classify u_cls (
      .ftype(hdr_use.ftype), .ttype(hdr_use.ttype),
      .kind(kind), .wants_rsp(wants_rsp), .is_read(is_read)
   );

   rio_size_decode #(.CNT_W(PAY_W)) u_sz (
      .size(hdr_use.size), .wdptr(hdr_use.wdptr), .is_read(is_read),
      .ok(sz_ok), .bytes(sz_bytes)
   );

   rio_addr_windows #(.ADDR_W(ADDR_W), .NWIN(NWIN)) u_win (
      .addr(addr_use), .win_en(win_en), .win_base(win_base),
      .win_mask(win_mask), .hit(win_hit)
   );

   logic bad, pay_zero, pay_unaligned, sz_unaligned;
   assign pay_zero      = (i_pay_bytes == '0);
   assign pay_unaligned = (i_pay_bytes[LANE_LG-1:0] != '0);
   assign sz_unaligned  = (sz_bytes[LANE_LG-1:0] != '0);

   always_comb begin
      bad = (hdr_use.prio == 2'd3) || (hdr_use.hdr_bytes < 8'(HDR_MIN));
      unique case (kind)
         K_NREAD:
            bad = bad || !pay_zero || !win_hit || !sz_ok || sz_unaligned;
         K_NWRITE, K_NWRITE_R:
            bad = bad || pay_zero || !win_hit || !sz_ok ||
                  (i_pay_bytes != sz_bytes);
         K_SWRITE:
            bad = bad || pay_zero || pay_unaligned || !win_hit ||
                  (i_pay_bytes > PAY_W'(SW_MAX));
         K_ATOMIC:
            bad = bad || !sz_ok || (i_pay_bytes != sz_bytes);
         default: bad = 1'b0;
      endcase
   end

   logic judge;
   assign judge = pkt_end && i_crc_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_accept  <= 1'b0;
         o_illegal <= 1'b0;
         o_pass    <= 1'b0;
         o_err_rsp <= 1'b0;
      end else begin
         o_pass    <= judge && (kind == K_OTHER);
         o_illegal <= judge && (kind != K_OTHER) && bad;
         o_accept  <= judge && (kind != K_OTHER) && !bad;
         o_err_rsp <= (judge && (kind != K_OTHER) && bad && wants_rsp) ||
                      (rd_last && rd_err);
      end
   end

   assert_one_verdict_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({o_accept, o_illegal, o_pass}));
   assert_verdict_follows_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (o_accept || o_illegal || o_pass) |-> $past(pkt_end && i_crc_ok));
   assert_good_end_gives_verdict_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_end && i_crc_ok) |=> (o_accept || o_illegal || o_pass));
   assert_read_error_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_last && rd_err) |=> o_err_rsp);
   assert_accept_no_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (o_accept && !$past(rd_last && rd_err)) |-> !o_err_rsp);
endmodule

// File: tb/rio_req_check_tb.sv
module rio_req_check_tb;
   localparam int AW = 32;
   localparam int NW = 4;
   localparam int PW = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          pkt_start = 0, pkt_end = 0, crc_ok = 1, rd_last = 0, rd_err = 0, wdptr = 0;
   logic [3:0]    ftype = 0, ttype = 0, size = 0;
   logic [1:0]    prio = 0;
   logic [AW-1:0] addr = 0;
   logic [7:0]    hdr_bytes = 12;
   logic [PW-1:0] pay = 0;
   logic [NW-1:0] w_en = 4'b1011;
   logic [AW-1:0] w_base [NW] = '{32'h0000_0000, 32'h8000_0000, 32'h4000_0000, 32'h2000_0000};
   logic [AW-1:0] w_mask [NW] = '{32'hFFFF_0000, 32'hF000_0000, 32'hF000_0000, 32'hFFFF_F000};
   logic [NW*AW-1:0] base_flat, mask_flat;
   always_comb for (int i = 0; i < NW; i++) begin
      base_flat[i*AW +: AW] = w_base[i];
      mask_flat[i*AW +: AW] = w_mask[i];
   end

   logic acc, ill, pas, ersp;

   rio_req_check u_dut (
      .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .i_ftype(ftype), .i_ttype(ttype),
      .i_prio(prio), .i_size(size), .i_wdptr(wdptr), .i_addr(addr), .i_hdr_bytes(hdr_bytes),
      .pkt_end(pkt_end), .i_pay_bytes(pay), .i_crc_ok(crc_ok), .rd_last(rd_last),
      .rd_err(rd_err), .win_en(w_en), .win_base(base_flat), .win_mask(mask_flat),
      .o_accept(acc), .o_illegal(ill), .o_pass(pas), .o_err_rsp(ersp)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   task automatic check(string req, logic [3:0] act, logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {acc,ill,pass,err} actual %b expected %b", req, act, exp);
      end
   endtask

   // R12 byte map, bit 9 = encoding usable
   function automatic logic [9:0] size_map(logic [3:0] s, logic w, logic rd);
      logic [8:0] n;
      logic       ok = 1'b1;
      case (s)
         0, 1, 2, 3: n = 1;
         4, 6:  n = 2;
         5:     n = 3;
         7:     n = 5;
         8:     n = 4;
         9:     n = 6;
         10:    n = 7;
         11:    n = w ? 16 : 8;
         12:    n = w ? 64 : 32;
         13: begin n = w ? 128 : 96;  ok = rd || w; end
         14: begin n = w ? 192 : 160; ok = rd; end
         default: begin n = w ? 256 : 224; ok = rd; end
      endcase
      return {ok, n};
   endfunction

   function automatic logic win_model(logic [AW-1:0] a);
      for (int i = 0; i < NW; i++)
         if (w_en[i] && ((a ^ w_base[i]) & w_mask[i]) == 0) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [3:0] model();
      // 0 NREAD 1 NWRITE 2 NWRITE_R 3 SWRITE 4 ATOMIC 5 other (R10)
      int k = 5;
      logic e, rsp;
      logic [9:0] sm;
      if (!crc_ok) return 4'b0000;
      if (ftype == 2 && ttype == 4) k = 0;
      else if (ftype == 5 && ttype == 4) k = 1;
      else if (ftype == 5 && ttype == 5) k = 2;
      else if (ftype == 5 && ttype >= 12 && ttype <= 14) k = 4;
      else if (ftype == 6) k = 3;
      if (k == 5) return 4'b0010;
      sm = size_map(size, wdptr, k == 0);
      e = (prio == 3) || (hdr_bytes < 12);
      case (k)
         0: e = e || pay != 0 || !win_model(addr) || !sm[9] || (sm[8:0] % 8 != 0);
         1, 2: e = e || pay == 0 || !win_model(addr) || !sm[9] || pay != sm[8:0];
         3: e = e || pay == 0 || (pay % 8 != 0) || pay > 256 || !win_model(addr);
         default: e = e || !sm[9] || pay != sm[8:0];
      endcase
      rsp = e && (k == 0 || k == 2 || k == 4);
      return e ? {2'b01, 1'b0, rsp} : 4'b1000;
   endfunction

   task automatic run_pkt(string req, bit split);
      logic [3:0] exp;
      @(negedge clk);
      exp = model();
      pkt_start = 1;
      if (!split) pkt_end = 1;
      if (split) begin
         @(negedge clk);
         pkt_start = 0;
         ftype = 4'($urandom); ttype = 4'($urandom); prio = 2'($urandom);
         size = 4'($urandom); addr = $urandom; hdr_bytes = 8'($urandom);
         pkt_end = 1;
      end
      @(negedge clk);
      pkt_start = 0; pkt_end = 0;
      check(req, {acc, ill, pas, ersp}, exp);
      @(negedge clk);
      check({req, " R1 single pulse"}, {acc, ill, pas, ersp}, 4'b0000);
   endtask

   task automatic set_pkt(logic [3:0] f, logic [3:0] t, logic [1:0] p, logic [3:0] s,
                          logic w, logic [AW-1:0] a, logic [PW-1:0] pl);
      ftype = f; ttype = t; prio = p; size = s; wdptr = w; addr = a; pay = pl;
      hdr_bytes = 12; crc_ok = 1;
   endtask

   function automatic logic [AW-1:0] pick_addr();
      case ($urandom % 6)
         0: return 32'h0000_1234;
         1: return 32'h8ABC_0000;
         2: return 32'h4000_0010;
         3: return 32'h2000_0FF0;
         4: return 32'h2000_1000;
         default: return $urandom;
      endcase
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 reset", {acc, ill, pas, ersp}, 4'b0000);
      rst_n = 1;

      set_pkt(5, 5, 0, 11, 0, 32'h0000_0100, 8);  run_pkt("R7 NWRITE_R legal", 0);
      set_pkt(5, 5, 3, 11, 0, 32'h0000_0100, 8);  run_pkt("R2 prio3 NWRITE_R", 0);
      set_pkt(5, 4, 0, 11, 0, 32'h0000_0100, 0);  run_pkt("R3 NWRITE empty", 0);
      set_pkt(2, 4, 0, 11, 1, 32'h8000_0000, 16); run_pkt("R3 NREAD payload", 0);
      set_pkt(5, 4, 0, 14, 0, 32'h0000_0100, 160); run_pkt("R5 reserved write size", 0);
      set_pkt(5, 5, 0, 13, 0, 32'h0000_0100, 96); run_pkt("R5 reserved 13/0", 0);
      set_pkt(5, 5, 0, 13, 1, 32'h0000_0100, 128); run_pkt("R12 128-byte write", 0);
      set_pkt(2, 4, 0, 7, 0, 32'h0000_0100, 0);   run_pkt("R6 NREAD 5 bytes", 0);
      set_pkt(2, 4, 0, 15, 1, 32'h0000_0100, 0);  run_pkt("R6 NREAD 256", 0);
      set_pkt(2, 4, 0, 11, 0, 32'h4000_0010, 0);  run_pkt("R4 disabled window", 0);
      set_pkt(2, 4, 0, 11, 0, 32'h2000_0FF8, 0);  run_pkt("R4 window3 hit", 0);
      set_pkt(6, 0, 0, 0, 0, 32'h2000_1000, 8);   run_pkt("R4 R8 SWRITE miss no rsp", 0);
      set_pkt(6, 0, 0, 0, 0, 32'h2000_0000, 256); run_pkt("R7 SWRITE 256", 0);
      set_pkt(6, 0, 0, 0, 0, 32'h2000_0000, 12);  run_pkt("R7 SWRITE unaligned", 0);
      set_pkt(5, 12, 0, 8, 0, 32'hFFFF_FFFF, 4);  run_pkt("R7 ATOMIC legal", 0);
      set_pkt(5, 12, 0, 8, 0, 32'h0, 2);          run_pkt("R7 R8 ATOMIC length", 0);
      set_pkt(5, 4, 0, 11, 0, 32'h0, 8); hdr_bytes = 11; run_pkt("R7 short header", 0);
      set_pkt(8, 0, 3, 15, 0, 32'h4000_0000, 0);  run_pkt("R10 pass-through", 0);
      set_pkt(2, 1, 0, 0, 0, 32'h0, 0);           run_pkt("R10 ftype2 other", 0);
      set_pkt(8, 0, 0, 0, 0, 32'h0, 0); crc_ok = 0; run_pkt("R1 bad CRC", 0);
      set_pkt(5, 4, 0, 12, 1, 32'h8000_0040, 64); run_pkt("R11 split legal", 1);
      set_pkt(5, 5, 3, 12, 1, 32'h8000_0040, 64); run_pkt("R11 split illegal", 1);

      @(negedge clk); rd_last = 1; rd_err = 1;
      @(negedge clk); rd_last = 0; rd_err = 0;
      check("R9 read error", {acc, ill, pas, ersp}, 4'b0001);
      @(negedge clk); rd_last = 1; rd_err = 0;
      @(negedge clk); rd_last = 0;
      check("R9 clean read", {acc, ill, pas, ersp}, 4'b0000);

      for (int n = 0; n < 400; n++) begin
         case ($urandom % 5)
            0: begin ftype = 2; ttype = ($urandom % 3 == 0) ? 4'($urandom) : 4; end
            1, 2: begin ftype = 5; ttype = 4'($urandom); end
            3: begin ftype = 6; ttype = 4'($urandom); end
            default: begin ftype = 4'($urandom); ttype = 4'($urandom); end
         endcase
         prio = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
         size = 4'($urandom); wdptr = 1'($urandom);
         addr = pick_addr();
         hdr_bytes = ($urandom % 10 == 0) ? 8'($urandom % 12) : 8'd12;
         crc_ok = ($urandom % 12 != 0);
         case ($urandom % 4)
            0: pay = PW'($urandom);
            1: pay = 0;
            2: pay = PW'(($urandom % 33) * 8);
            default: pay = size_map(size, wdptr, 1'b0)[8:0];
         endcase
         run_pkt("R1-mix random", ($urandom % 4) == 0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      done = 1;
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule